// File: doc/BRIEF.md
# Bidirectional Inverting Latched Bus Transceiver

This block sits between two 8-bit bus segments, called side A and side B, and moves data across in either direction through its own bank of storage. The A-to-B direction keeps A-side data for driving side B, and the B-to-A direction keeps B-side data for driving side A. Each direction has three active-low controls. A path enable opens the whole direction. A latch enable lets new data into the bank. A drive enable turns on that direction's output drivers. What a direction puts on the far bus is always the bitwise complement of its bank.

The banks are registers sampled on the system clock. A bank loads its near-side input on every clock while both its path enable and its latch enable are low. It keeps its value from the last such clock once either of the two goes high. That clock is the sampled form of a rising-edge capture.

Pins are not tristate. Each side has a separate input vector, a data output vector and a per-bit drive-enable vector, where a low enable bit means the pin is not driven. The block does not arbitrate between the two directions. Keeping both directions from driving the same pins at once is the job of whatever controls the block.

Top module: `inv_latch_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both banks to zero and clears both drive-enable vectors. While reset is applied, both data outputs therefore read all ones.
- R2: While the A-to-B path enable and latch enable are both low, each clock loads `a_in` into the A-to-B bank. One cycle later `b_out` equals the bitwise inverse of that `a_in`.
- R3: While the B-to-A path enable and latch enable are both low, each clock loads `b_in` into the B-to-A bank. One cycle later `a_out` equals the bitwise inverse of that `b_in`.
- R4: While a direction's latch enable is high, its bank and its data output stay unchanged whatever its near-side input does.
- R5: While a direction's path enable is high, its bank holds and its drive-enable vector is all zeros. When the path enable returns low with the latch enable still high, the output shows the value held from before.
- R6: One clock after a direction's path enable and drive enable are both low, its drive-enable vector is all ones (bit value 1 means driven). One clock after either control is high, the vector is all zeros. No other pattern occurs.
- R7: A data output always equals the inverse of its bank, including while that direction's drive-enable vector is all zeros.
- R8: The two directions are independent. No A-to-B control or `a_in` value changes `a_out` or `a_oe`, and no B-to-A control or `b_in` value changes `b_out` or `b_oe`.
- R9: The block does not resolve contention. When both directions are told to drive, both drive-enable vectors assert. A monitor at the block's edge detects this as contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data seen on side A pins |
| b_in | input | W | Data seen on side B pins |
| ab_path_n | input | 1 | A-to-B path enable, active low |
| ab_latch_n | input | 1 | A-to-B latch enable, active low |
| ab_drive_n | input | 1 | A-to-B drive enable, active low |
| ba_path_n | input | 1 | B-to-A path enable, active low |
| ba_latch_n | input | 1 | B-to-A latch enable, active low |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |
| a_out | output | W | Value for side A pins (inverse of B-to-A bank) |
| a_oe | output | W | Per-bit drive enable for side A, 1 = driven |
| b_out | output | W | Value for side B pins (inverse of A-to-B bank) |
| b_oe | output | W | Per-bit drive enable for side B, 1 = driven |

## Verification
Each direction is fed complementary and alternating data patterns such as 3C, F0, 81 and 00. These patterns catch missing or partial inversion and bits swapped between lanes. The control triples are walked through transparent, latch-held, path-off and drive-off states in turn. This separates a hold caused by the latch enable from one caused by the path enable, and separates data gating from drive gating. A direction is also loaded while its drivers are off, which shows that the data output tracks the bank whatever the drive state. Finally, both directions are driven at once so the contention monitor must trip, and a reset is applied in the middle of the run with both banks loaded.

// File: rtl/ilx_pkg.sv
package ilx_pkg;

    localparam int unsigned DIR_CNT = 2;
    localparam int unsigned DIR_AB  = 0;
    localparam int unsigned DIR_BA  = 1;

    // Raw active-low controls of one direction
    typedef struct packed {
        logic path_n;
        logic latch_n;
        logic drive_n;
    } dir_ctl_t;

    // Decoded active-high commands of one direction
    typedef struct packed {
        logic capture;
        logic drive;
    } dir_cmd_t;

    function automatic dir_cmd_t decode_ctl(input dir_ctl_t c);
        dir_cmd_t r;
        r.capture = !c.path_n && !c.latch_n;
        r.drive   = !c.path_n && !c.drive_n;
        return r;
    endfunction

endpackage

// File: rtl/xcvr_ctl_decode.sv
module xcvr_ctl_decode
    import ilx_pkg::*;
(
    input  dir_ctl_t ctl,
    output dir_cmd_t cmd
);

    assign cmd = decode_ctl(ctl);

endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         capture,
    input  logic         drive,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);

    localparam logic [W-1:0] ALL_ON = {W{1'b1}};

    logic [W-1:0] bank_q;
    logic [W-1:0] oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            oe_q   <= '0;
        end else begin
            if (capture) begin
                bank_q <= din;
            end
            oe_q <= {W{drive}};
        end
    end

    assign dout = ~bank_q;
    assign oe   = oe_q;

    // R1: reset clears storage and drive
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (bank_q == '0) && (oe_q == '0));

    // R4: no load command means the bank keeps its value
    p_hold_bank_r4: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(bank_q));

    // R2 / R3: a load command stores the near-side data
    p_load_bank_r2: assert property (@(posedge clk) disable iff (rst)
        capture |=> bank_q == $past(din));

    // R6: the drive vector is either fully on or fully off
    p_oe_uniform_r6: assert property (@(posedge clk) disable iff (rst)
        (oe == '0) || (oe == ALL_ON));

endmodule

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr
    import ilx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_path_n,
    input  logic         ab_latch_n,
    input  logic         ab_drive_n,
    input  logic         ba_path_n,
    input  logic         ba_latch_n,
    input  logic         ba_drive_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    localparam logic [W-1:0] ALL_ON = {W{1'b1}};

    dir_ctl_t     ctl  [DIR_CNT];
    logic [W-1:0] din  [DIR_CNT];
    logic [W-1:0] dout [DIR_CNT];
    logic [W-1:0] oe   [DIR_CNT];

    assign ctl[DIR_AB] = dir_ctl_t'{path_n: ab_path_n, latch_n: ab_latch_n, drive_n: ab_drive_n};
    assign ctl[DIR_BA] = dir_ctl_t'{path_n: ba_path_n, latch_n: ba_latch_n, drive_n: ba_drive_n};
    assign din[DIR_AB] = a_in;
    assign din[DIR_BA] = b_in;

    for (genvar d = 0; d < DIR_CNT; d++) begin : g_dir
        dir_cmd_t cmd;

        xcvr_ctl_decode u_dec (
            .ctl (ctl[d]),
            .cmd (cmd)
        );

        xcvr_bank #(.W(W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .din     (din[d]),
            .capture (cmd.capture),
            .drive   (cmd.drive),
            .dout    (dout[d]),
            .oe      (oe[d])
        );
    end

    assign b_out = dout[DIR_AB];
    assign b_oe  = oe[DIR_AB];
    assign a_out = dout[DIR_BA];
    assign a_oe  = oe[DIR_BA];

    // R2: transparent A-to-B shows the inverse of the sampled A data
    p_ab_invert_r2: assert property (@(posedge clk) disable iff (rst)
        (!ab_path_n && !ab_latch_n) |=> b_out == ~$past(a_in));

    // R3: transparent B-to-A shows the inverse of the sampled B data
    p_ba_invert_r3: assert property (@(posedge clk) disable iff (rst)
        (!ba_path_n && !ba_latch_n) |=> a_out == ~$past(b_in));

    // R6: drive enable follows path and drive controls
    p_ab_drive_on_r6: assert property (@(posedge clk) disable iff (rst)
        (!ab_path_n && !ab_drive_n) |=> b_oe == ALL_ON);
    p_ab_drive_off_r6: assert property (@(posedge clk) disable iff (rst)
        (ab_path_n || ab_drive_n) |=> b_oe == '0);

    // R5 / R8: a closed B-to-A path leaves side A untouched by anything
    p_ba_closed_r8: assert property (@(posedge clk) disable iff (rst)
        ba_path_n |=> $stable(a_out) && (a_oe == '0));

endmodule

// File: tb/inv_latch_xcvr_tb_top.sv
module inv_latch_xcvr_tb_top;

    localparam int W        = 8;
    localparam int CLK_PER  = 10;
    localparam int N_VEC    = 12;
    localparam int WD_LIMIT = 5000;

    // ctl = {ab_path_n, ab_latch_n, ab_drive_n, ba_path_n, ba_latch_n, ba_drive_n}
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [5:0]   ctl;
        logic [W-1:0] x_a_out;
        logic [W-1:0] x_a_oe;
        logic [W-1:0] x_b_out;
        logic [W-1:0] x_b_oe;
    } vec_t;

    // Starts from reset: both banks zero.
    localparam vec_t TBL [N_VEC] = '{
        '{8'h3C, 8'hA5, 6'b000_111, 8'hFF, 8'h00, 8'hC3, 8'hFF}, // 0 R2
        '{8'hF0, 8'hA5, 6'b000_111, 8'hFF, 8'h00, 8'h0F, 8'hFF}, // 1 R2
        '{8'h55, 8'hA5, 6'b010_111, 8'hFF, 8'h00, 8'h0F, 8'hFF}, // 2 R4
        '{8'hAA, 8'hA5, 6'b110_111, 8'hFF, 8'h00, 8'h0F, 8'h00}, // 3 R5
        '{8'hAA, 8'hA5, 6'b011_111, 8'hFF, 8'h00, 8'h0F, 8'h00}, // 4 R6
        '{8'hAA, 8'hA5, 6'b010_111, 8'hFF, 8'h00, 8'h0F, 8'hFF}, // 5 R5
        '{8'hAA, 8'h81, 6'b111_000, 8'h7E, 8'hFF, 8'h0F, 8'h00}, // 6 R3
        '{8'h12, 8'h00, 6'b111_000, 8'hFF, 8'hFF, 8'h0F, 8'h00}, // 7 R8
        '{8'h12, 8'hFF, 6'b111_100, 8'hFF, 8'h00, 8'h0F, 8'h00}, // 8 R5
        '{8'h12, 8'hFF, 6'b111_001, 8'h00, 8'h00, 8'h0F, 8'h00}, // 9 R7
        '{8'h12, 8'hFF, 6'b111_000, 8'h00, 8'hFF, 8'h0F, 8'h00}, // 10 R6
        '{8'h12, 8'h0F, 6'b111_010, 8'h00, 8'hFF, 8'h0F, 8'h00}  // 11 R4
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1:  return "R2";
            2, 11: return "R4";
            3, 5, 8: return "R5";
            4, 10: return "R6";
            6:     return "R3";
            7:     return "R8";
            default: return "R7";
        endcase
    endfunction

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [5:0]   ctl = 6'b111_111;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_chk = 0;
    int n_bad = 0;
    int contention_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    inv_latch_xcvr #(.W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .a_in       (a_in),
        .b_in       (b_in),
        .ab_path_n  (ctl[5]),
        .ab_latch_n (ctl[4]),
        .ab_drive_n (ctl[3]),
        .ba_path_n  (ctl[2]),
        .ba_latch_n (ctl[1]),
        .ba_drive_n (ctl[0]),
        .a_out      (a_out),
        .a_oe       (a_oe),
        .b_out      (b_out),
        .b_oe       (b_oe)
    );

    // Contention monitor (R9): both sides driving the same bit
    always @(negedge clk) begin
        if (!rst && ((a_oe & b_oe) != '0)) contention_cnt++;
    end

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [W-1:0] xa, input logic [W-1:0] xaoe,
                           input logic [W-1:0] xb, input logic [W-1:0] xboe);
        chk(req, "a_out", a_out, xa);
        chk(req, "a_oe",  a_oe,  xaoe);
        chk(req, "b_out", b_out, xb);
        chk(req, "b_oe",  b_oe,  xboe);
    endtask

    // Inputs change at a falling edge; results are read at the next falling edge
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic [5:0] c);
        a_in = a;
        b_in = b;
        ctl  = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R1", 8'hFF, 8'h00, 8'hFF, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            step(TBL[i].a, TBL[i].b, TBL[i].ctl);
            chk_all(row_req(i), TBL[i].x_a_out, TBL[i].x_a_oe, TBL[i].x_b_out, TBL[i].x_b_oe);
        end

        // R9: no contention so far, then force both directions to drive
        n_chk++;
        if (contention_cnt != 0) begin
            n_bad++;
            $display("FAIL R9 early contention: actual %0d expected 0", contention_cnt);
        end
        step(8'h01, 8'h02, 6'b000_000);
        chk_all("R9", 8'hFD, 8'hFF, 8'hFE, 8'hFF);
        @(negedge clk);
        n_chk++;
        if (contention_cnt == 0) begin
            n_bad++;
            $display("FAIL R9 contention flag: actual %0d expected >0", contention_cnt);
        end

        // R1: reset in mid-run with both banks loaded
        ctl = 6'b111_111;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_all("R1", 8'hFF, 8'h00, 8'hFF, 8'h00);
        rst = 1'b0;

        // R8: A-to-B traffic leaves side A as reset left it
        step(8'h99, 8'h66, 6'b000_111);
        chk_all("R8", 8'hFF, 8'h00, 8'h66, 8'hFF);

        done = 1'b1;
        finish_run();
    end

endmodule